// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Macrocells

This block is a small programmable logic device. A configurable AND plane builds product terms from the dedicated inputs and from the outputs fed back into it, each available in true and inverted form. For every output a fixed group of product terms is ORed together and passed to an output macrocell. The macrocell either passes the result straight through (combinational) or holds it in a flip-flop (registered). It can invert the result, gates its pad driver with a per-output enable, and returns its value to the AND plane. Through that return path logic can take two passes through the array: an output computing A+B can be reused by another output as one literal of A+B+Z, with no duplicated product terms.

The whole configuration is static. A fuse vector picks which literals join each product term. One mode bit per output selects registered operation, and one invert bit per output sets polarity. There is no data stream at the edges, so all pins are plain levels with no valid/ready handshake: outputs follow inputs in the same cycle in combinational mode and on the next rising edge in registered mode.

Top module: `pla_array`

## Requirements
- R1: Literal column numbering. Input i drives column 2*i with its true value and column 2*i+1 with its inverse. Feedback k drives column 2*(N_IN+k) true and 2*(N_IN+k)+1 inverted. Fuse bit (o*N_PT+p)*N_COL+c set to 1 connects column c into product term p of output o, and the term is the AND of its connected literals.
- R2: A product term with no fuse set evaluates to 1.
- R3: A product term that connects both the true and the inverted column of the same signal evaluates to 0.
- R4: Each output's sum is the OR of its N_PT product terms.
- R5: When invert_i[o] is 1 the sum of output o is inverted before it reaches the register, the pad and the combinational feedback.
- R6: With reg_mode_i[o]=0, pad_o[o] equals the polarity-adjusted sum in the same cycle.
- R7: With reg_mode_i[o]=1, pad_o[o] equals the value the polarity-adjusted sum had before the last rising clock edge.
- R8: rst_i is sampled on the rising edge and clears every output register to 0.
- R9: In combinational mode, feedback k carries pad_o[k] into the array.
- R10: In registered mode, feedback k carries the inverse of the register (column 2*(N_IN+k) sees the inverted register value).
- R11: pad_oe_o[o] follows oe_i[o]. When it is 0 the pad is left undriven, and neither pad_o nor the feedback depends on oe_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output registers |
| rst_i | input | 1 | Synchronous reset, active high |
| in_i | input | N_IN | Dedicated logic inputs |
| fuse_i | input | N_OUT*N_PT*2*(N_IN+N_OUT) | AND-plane connection map |
| reg_mode_i | input | N_OUT | 1 = registered output, 0 = combinational |
| invert_i | input | N_OUT | 1 = invert the OR result |
| oe_i | input | N_OUT | Per-output pad driver enable |
| pad_o | output | N_OUT | Output value to the pad |
| pad_oe_o | output | N_OUT | Pad driver enable; 0 = high impedance |

## Verification
The bench builds the array with its default size: 8 inputs, 4 outputs and 4 product terms per output. With 8 inputs every one of the 256 input combinations can be applied in each mode setting. It loads one acyclic two-pass configuration, in which one output ORs another output's feedback with a fresh input, alongside an inverted term, an empty term and contradictory terms. It then sweeps all combinations with every output combinational, every output registered, and a mixed setting. A reset is applied mid-sweep.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic {
    MC_COMB = 1'b0,
    MC_REG  = 1'b1
  } mc_mode_e;

  // number of AND-plane columns for a given input and feedback count
  function automatic int col_count(input int n_in, input int n_fb);
    return 2 * (n_in + n_fb);
  endfunction
endpackage

// File: rtl/pla_pterm.sv
module pla_pterm #(
  parameter int N_COL = 24
) (
  input  logic [N_COL-1:0] lit_i,
  input  logic [N_COL-1:0] fuse_i,
  output logic             term_o
);
  // unconnected columns contribute a 1; an empty term is therefore 1
  assign term_o = &(lit_i | ~fuse_i);
endmodule

// File: rtl/pla_macrocell.sv
module pla_macrocell
  import pla_pkg::*;
#(
  parameter int N_PT = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [N_PT-1:0] term_i,
  input  logic            reg_mode_i,
  input  logic            invert_i,
  output logic            out_o,
  output logic            fb_o,
  output logic            d_o,
  output logic            q_o
);
  mc_mode_e mode;
  logic     sum;
  logic     q;

  assign mode = mc_mode_e'(reg_mode_i);
  assign sum  = |term_i;
  assign d_o  = sum ^ invert_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) q <= 1'b0;
    else       q <= d_o;
  end

  assign q_o = q;

  always_comb begin
    if (mode == MC_REG) begin
      out_o = q;
      fb_o  = ~q;
    end else begin
      out_o = d_o;
      fb_o  = d_o;
    end
  end
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4,
  parameter int N_PT  = 4,
  localparam int N_COL  = 2 * (N_IN + N_OUT),
  localparam int N_TERM = N_OUT * N_PT,
  localparam int FUSE_W = N_TERM * N_COL
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [N_IN-1:0]   in_i,
  input  logic [FUSE_W-1:0] fuse_i,
  input  logic [N_OUT-1:0]  reg_mode_i,
  input  logic [N_OUT-1:0]  invert_i,
  input  logic [N_OUT-1:0]  oe_i,
  output logic [N_OUT-1:0]  pad_o,
  output logic              [N_OUT-1:0] pad_oe_o
);
  logic [N_COL-1:0]  lit;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  fb;
  logic [N_OUT-1:0]  d_vec;
  logic [N_OUT-1:0]  q_vec;

  // literal columns: true then inverted, inputs first, feedback after
  for (genvar i = 0; i < N_IN; i++) begin : g_in_lit
    assign lit[2*i]   = in_i[i];
    assign lit[2*i+1] = ~in_i[i];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_fb_lit
    assign lit[2*(N_IN+k)]   = fb[k];
    assign lit[2*(N_IN+k)+1] = ~fb[k];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pla_pterm #(.N_COL(N_COL)) u_pterm (
      .lit_i  (lit),
      .fuse_i (fuse_i[t*N_COL +: N_COL]),
      .term_o (term[t])
    );
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_cell
    pla_macrocell #(.N_PT(N_PT)) u_cell (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .term_i     (term[o*N_PT +: N_PT]),
      .reg_mode_i (reg_mode_i[o]),
      .invert_i   (invert_i[o]),
      .out_o      (pad_o[o]),
      .fb_o       (fb[o]),
      .d_o        (d_vec[o]),
      .q_o        (q_vec[o])
    );
  end

  assign pad_oe_o = oe_i;
endmodule

// File: rtl/pla_array_sva.sv
module pla_array_sva #(
  parameter int N_OUT = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [N_OUT-1:0] reg_mode_i,
  input logic [N_OUT-1:0] oe_i,
  input logic [N_OUT-1:0] pad_o,
  input logic [N_OUT-1:0] pad_oe_o,
  input logic [N_OUT-1:0] d_vec_i,
  input logic [N_OUT-1:0] q_vec_i
);
  p_reset_clear_r8: assert property (@(posedge clk_i)
    rst_i |=> (q_vec_i == '0));

  p_reg_capture_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rst_i) |=> (q_vec_i == $past(d_vec_i)));

  p_reg_pad_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    ((pad_o & reg_mode_i) == (q_vec_i & reg_mode_i)));

  p_comb_pad_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    ((pad_o & ~reg_mode_i) == (d_vec_i & ~reg_mode_i)));

  p_pad_enable_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (pad_oe_o == oe_i));
endmodule

bind pla_array pla_array_sva #(.N_OUT(N_OUT)) u_sva (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .reg_mode_i (reg_mode_i),
  .oe_i       (oe_i),
  .pad_o      (pad_o),
  .pad_oe_o   (pad_oe_o),
  .d_vec_i    (d_vec),
  .q_vec_i    (q_vec)
);

// File: tb/test_pla_array.sv
module test_pla_array;
  localparam int NI   = 8;
  localparam int NO   = 4;
  localparam int NP   = 4;
  localparam int NC   = 2 * (NI + NO);
  localparam int FW   = NO * NP * NC;

  logic          clk = 1'b0;
  logic          rst_i;
  logic [NI-1:0] in_i;
  logic [FW-1:0] fuse_i;
  logic [NO-1:0] reg_mode_i;
  logic [NO-1:0] invert_i;
  logic [NO-1:0] oe_i;
  logic [NO-1:0] pad_o;
  logic [NO-1:0] pad_oe_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [NO-1:0] mq;   // model registers
  logic [NO-1:0] md;   // model polarity-adjusted sums
  logic [NO-1:0] mval; // model pad values

  always #2 clk = ~clk;

  pla_array #(.N_IN(NI), .N_OUT(NO), .N_PT(NP)) i_pla_array (
    .clk_i      (clk),
    .rst_i      (rst_i),
    .in_i       (in_i),
    .fuse_i     (fuse_i),
    .reg_mode_i (reg_mode_i),
    .invert_i   (invert_i),
    .oe_i       (oe_i),
    .pad_o      (pad_o),
    .pad_oe_o   (pad_oe_o)
  );

  task automatic connect(input int o, input int p, input int c);
    fuse_i[(o*NP+p)*NC + c] = 1'b1;
  endtask

  // behavioural reference: settle the feedback by repeated evaluation
  task automatic model_eval();
    logic [NO-1:0] fbv;
    logic [NC-1:0] lits;
    mval = '0;
    md   = '0;
    for (int pass = 0; pass <= NO; pass++) begin
      for (int k = 0; k < NO; k++) fbv[k] = reg_mode_i[k] ? ~mq[k] : mval[k];
      for (int i = 0; i < NI; i++) begin
        lits[2*i] = in_i[i]; lits[2*i+1] = ~in_i[i];
      end
      for (int k = 0; k < NO; k++) begin
        lits[2*(NI+k)] = fbv[k]; lits[2*(NI+k)+1] = ~fbv[k];
      end
      for (int o = 0; o < NO; o++) begin
        bit s = 1'b0;
        for (int p = 0; p < NP; p++) begin
          bit t = 1'b1;
          for (int c = 0; c < NC; c++)
            if (fuse_i[(o*NP+p)*NC + c] && !lits[c]) t = 1'b0;
          s = s | t;
        end
        md[o]   = s ^ invert_i[o];
        mval[o] = reg_mode_i[o] ? mq[o] : md[o];
      end
    end
  endtask

  task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (in=%h mode=%b)", req, act, exp, in_i, reg_mode_i);
    end
  endtask

  task automatic step(input logic [NI-1:0] x, input logic [NO-1:0] oe, input logic r, input string req);
    in_i  = x;
    oe_i  = oe;
    rst_i = r;
    #2;
    model_eval();
    check(req, pad_o, mval);
    check("R11 pad enable", pad_oe_o, oe);
    @(posedge clk);
    mq = r ? '0 : md;
    #1;
  endtask

  initial begin
    #(20000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_i = 1'b1; in_i = '0; oe_i = '0; invert_i = '0; reg_mode_i = '1;
    fuse_i = '0;
    mq = 'x;
    // out0 = in0 + in1, two contradictory terms (R3) must not force it high
    connect(0, 0, 0); connect(0, 1, 2);
    connect(0, 2, 0); connect(0, 2, 1);
    connect(0, 3, 2*(NI+0)); connect(0, 3, 2*(NI+0)+1);
    // out1 = fb0 + in2 (two-pass), rest contradictory
    connect(1, 0, 2*(NI+0)); connect(1, 1, 4);
    connect(1, 2, 6); connect(1, 2, 7);
    connect(1, 3, 9); connect(1, 3, 8);
    // out2 = ~(in3 & ~in4 & in5) + contradictory terms, inverted (R5)
    connect(2, 0, 6); connect(2, 0, 9); connect(2, 0, 10);
    for (int p = 1; p < NP; p++) begin connect(2, p, 12); connect(2, p, 13); end
    invert_i[2] = 1'b1;
    // out3: all terms empty -> constant 1 (R2)
    @(posedge clk); #1;
    @(posedge clk); #1;
    mq = '0;
    // reset state R8: all registered outputs read 0
    check("R8 reset state", pad_o, 4'b0000);

    // all combinational (R1 R2 R3 R4 R5 R6 R9)
    reg_mode_i = 4'b0000;
    for (int v = 0; v < 256; v++)
      step(NI'(v), NO'(v), 1'b0, "R1 R2 R3 R4 R5 R6 R9 comb");

    // all registered (R7 R10), reset mid-sweep (R8)
    reg_mode_i = 4'b1111;
    for (int v = 0; v < 256; v++)
      step(NI'(v), NO'(v >> 2), (v == 100), "R7 R8 R10 registered");

    // mixed: out0 registered feeding combinational out1, and vice versa
    reg_mode_i = 4'b0101;
    for (int v = 0; v < 256; v++)
      step(NI'(255 - v), NO'(v >> 4), 1'b0, "R6 R7 R9 R10 mixed");
    reg_mode_i = 4'b1010;
    for (int v = 0; v < 64; v++)
      step(NI'(v * 3), 4'b1111, 1'b0, "R6 R7 R9 R10 mixed");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule